// File: doc/BRIEF.md
# Predicated Execution Mode Controller

This block decides, one retiring instruction at a time, whether an in-order CPU may commit that instruction's effects. A condition-select instruction loads a sticky mode. While a test mode is held, each later instruction is committed only if that test passes on the current comparison flags. When the test fails, the instruction is suppressed and its register, temp and memory writes must all be blocked. The mode lasts until another condition-select instruction replaces it, or until a committed instruction writes the program counter (r7).

The flags come from outside: zero, carry (set when the compare borrowed, meaning the first operand was below the second unsigned), sign and overflow. A signed-compare bit is captured with the flags when the compare runs. Signed tests use sign XOR overflow, and unsigned tests use carry. One condition code requests a stop. It raises a sticky halt output that a simulation can use to end the run.

Top module: `cond_exec_ctrl`

## Requirements
- R1: After reset the controller is in unconditional mode: every valid instruction commits whatever the flags are, and `halt` is low.
- R2: A valid condition-select instruction (`is_cond`=1) always commits. It loads its 3-bit code as the new mode and replaces any mode already held.
- R3: Code 2 commits when `flag_zero`=1. Code 3 commits when `flag_zero`=0.
- R4: With `signed_cmp`=0, the tests use only carry and zero. Code 4 (greater or equal) needs carry=0. Code 5 (greater) needs carry=0 and zero=0. Code 6 (less or equal) needs carry=1 or zero=1. Code 7 (less) needs carry=1.
- R5: With `signed_cmp`=1, the tests for codes 4 to 7 replace carry with `flag_sign` XOR `flag_ovf` and ignore carry.
- R6: Code 0 returns the controller to unconditional mode from the next instruction on.
- R7: A committed instruction with `writes_pc`=1 returns the controller to unconditional mode from the next instruction on.
- R8: A suppressed instruction with `writes_pc`=1 leaves the active mode unchanged.
- R9: Code 1 sets `halt` at the next clock edge. `halt` then stays high until reset, and every later non-select instruction is suppressed while code 1 is the mode.
- R10: When `instr_valid`=0, `commit` is low and the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction retires this cycle |
| is_cond | input | 1 | The retiring instruction is a condition select |
| cond_code | input | 3 | Code carried by the condition select |
| flag_zero | input | 1 | Zero flag from the last compare |
| flag_carry | input | 1 | Borrow flag from the last compare |
| flag_sign | input | 1 | Sign flag from the last compare |
| flag_ovf | input | 1 | Overflow flag from the last compare |
| signed_cmp | input | 1 | The last compare was marked signed |
| writes_pc | input | 1 | The retiring instruction writes r7 |
| commit | output | 1 | Let the retiring instruction's effects happen |
| halt | output | 1 | Sticky stop request |

## Verification
The checker confirms on every cycle that:
- a select always commits and idle cycles never do;
- unconditional mode commits everything;
- committed program-counter writes clear the mode and suppressed ones keep it;
- the stop request is set by code 1 and then holds.

Only the bench scenarios can show that each test code computes the right answer from the flag pattern. These scenarios walk every code with both signed and unsigned flag sets, and they also cover replacement of one mode by another and the release of halt by reset.

// File: rtl/cxc_pkg.sv
package cxc_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CC_ALWAYS = 3'd0,
    CC_STOP   = 3'd1,
    CC_EQ     = 3'd2,
    CC_NE     = 3'd3,
    CC_GE     = 3'd4,
    CC_GT     = 3'd5,
    CC_LE     = 3'd6,
    CC_LT     = 3'd7
  } cc_e;

  // "below" is the ordering result of the last compare:
  // signed -> sign xor overflow, unsigned -> borrow.
  function automatic logic cc_below(input logic sgn, input logic c,
                                    input logic s, input logic v);
    return sgn ? (s ^ v) : c;
  endfunction

  function automatic logic cc_eval(input cc_e code, input logic sgn,
                                   input logic z, input logic c,
                                   input logic s, input logic v);
    logic lt;
    lt = cc_below(sgn, c, s, v);
    unique case (code)
      CC_ALWAYS: return 1'b1;
      CC_STOP:   return 1'b0;
      CC_EQ:     return z;
      CC_NE:     return ~z;
      CC_GE:     return ~lt;
      CC_GT:     return ~lt & ~z;
      CC_LE:     return lt | z;
      CC_LT:     return lt;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cxc_cond_eval.sv
module cxc_cond_eval
  import cxc_pkg::*;
(
  input  cc_e  mode,
  input  logic sgn,
  input  logic z,
  input  logic c,
  input  logic s,
  input  logic v,
  output logic pass
);
  always_comb pass = cc_eval(mode, sgn, z, c, s, v);
endmodule

// File: rtl/cxc_mode_reg.sv
module cxc_mode_reg
  import cxc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  cc_e  load_code,
  input  logic clear_en,
  output cc_e  mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= CC_ALWAYS;
    else if (load_en)  mode_q <= load_code;
    else if (clear_en) mode_q <= CC_ALWAYS;
  end
endmodule

// File: rtl/cxc_halt_latch.sv
module cxc_halt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  output logic halt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      halt_q <= 1'b0;
    else if (set_en) halt_q <= 1'b1;
  end
endmodule

// File: rtl/cond_exec_ctrl.sv
module cond_exec_ctrl
  import cxc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic              is_cond,
  input  logic [CODE_W-1:0] cond_code,
  input  logic              flag_zero,
  input  logic              flag_carry,
  input  logic              flag_sign,
  input  logic              flag_ovf,
  input  logic              signed_cmp,
  input  logic              writes_pc,
  output logic              commit,
  output logic              halt
);
  cc_e  mode_q;
  cc_e  sel_code;
  logic cond_fire;
  logic test_pass;
  logic pc_clear;
  logic stop_fire;

  assign sel_code  = cc_e'(cond_code);
  assign cond_fire = instr_valid & is_cond;
  assign stop_fire = cond_fire & (sel_code == CC_STOP);

  cxc_cond_eval u_eval (
    .mode (mode_q),
    .sgn  (signed_cmp),
    .z    (flag_zero),
    .c    (flag_carry),
    .s    (flag_sign),
    .v    (flag_ovf),
    .pass (test_pass)
  );

  assign commit   = instr_valid & (is_cond | test_pass);
  assign pc_clear = instr_valid & ~is_cond & commit & writes_pc;

  cxc_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (cond_fire),
    .load_code (sel_code),
    .clear_en  (pc_clear),
    .mode_q    (mode_q)
  );

  cxc_halt_latch u_halt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (stop_fire),
    .halt_q (halt)
  );
endmodule

// File: rtl/cxc_checker.sv
module cxc_checker
  import cxc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              is_cond,
  input logic [CODE_W-1:0] cond_code,
  input logic              writes_pc,
  input logic              commit,
  input logic              halt,
  input cc_e               mode_q
);
  AST_SELECT_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && is_cond |-> commit); // R2
  AST_SELECT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && is_cond |=> mode_q == $past(cond_code)); // R2
  AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !commit); // R10
  AST_IDLE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(mode_q)); // R10
  AST_UNCOND_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && mode_q == CC_ALWAYS |-> commit); // R1
  AST_PC_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !is_cond && commit && writes_pc |=> mode_q == CC_ALWAYS); // R7
  AST_SUPPRESSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !is_cond && !commit |=> $stable(mode_q)); // R8
  AST_STOP_SETS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && is_cond && cond_code == 3'd1 |=> halt); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt); // R9
  AST_STOP_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !is_cond && mode_q == CC_STOP |-> !commit); // R9
endmodule

bind cond_exec_ctrl cxc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .is_cond     (is_cond),
  .cond_code   (cond_code),
  .writes_pc   (writes_pc),
  .commit      (commit),
  .halt        (halt),
  .mode_q      (mode_q)
);

// File: tb/tb_cond_exec_ctrl.sv
`timescale 1ns/1ps
module tb_cond_exec_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic instr_valid, is_cond, flag_zero, flag_carry, flag_sign, flag_ovf;
  logic signed_cmp, writes_pc, commit, halt;
  logic [2:0] cond_code;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cond_exec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .is_cond(is_cond),
    .cond_code(cond_code), .flag_zero(flag_zero), .flag_carry(flag_carry),
    .flag_sign(flag_sign), .flag_ovf(flag_ovf), .signed_cmp(signed_cmp),
    .writes_pc(writes_pc), .commit(commit), .halt(halt)
  );

  // {code[2:0], signed, zero, carry, sign, ovf, expected commit}
  localparam logic [8:0] VEC [18] = '{
    {3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {3'd6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic ic, input logic [2:0] cc,
                       input logic sg, input logic z, input logic c,
                       input logic s, input logic ov, input logic pc);
    @(negedge clk);
    instr_valid = v; is_cond = ic; cond_code = cc; signed_cmp = sg;
    flag_zero = z; flag_carry = c; flag_sign = s; flag_ovf = ov; writes_pc = pc;
    #1;
  endtask

  task automatic sel(input logic [2:0] cc);
    drive(1, 1, cc, 0, 0, 0, 0, 0, 0);
    check("R2 select commits", commit, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    instr_valid = 0; is_cond = 0; cond_code = 0; signed_cmp = 0;
    flag_zero = 0; flag_carry = 0; flag_sign = 0; flag_ovf = 0; writes_pc = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1 halt low", halt, 1'b0);
    drive(1, 0, 0, 0, 0, 1, 1, 0, 0);
    check("R1 unconditional commit", commit, 1'b1);

    // table walk: R3 R4 R5
    foreach (VEC[i]) begin
      sel(VEC[i][8:6]);
      drive(1, 0, 0, VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], 0);
      check($sformatf("R3/R4/R5 vector %0d", i), commit, VEC[i][0]);
      sel(3'd0);
    end

    // R2: new select replaces old
    sel(3'd2); sel(3'd3);
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R2 replace", commit, 1'b1);

    // R6: code 0 clears
    sel(3'd2); sel(3'd0);
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R6 back to unconditional", commit, 1'b1);

    // R7: committed pc write clears
    sel(3'd2);
    drive(1, 0, 0, 0, 1, 0, 0, 0, 1);
    check("R7 pc write commits", commit, 1'b1);
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R7 mode cleared", commit, 1'b1);

    // R8: suppressed pc write keeps mode
    sel(3'd2);
    drive(1, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R8 pc write suppressed", commit, 1'b0);
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R8 mode kept", commit, 1'b0);
    drive(1, 0, 0, 0, 1, 0, 0, 0, 0);
    check("R8 mode still EQ", commit, 1'b1);
    sel(3'd0);

    // R10: idle cycle with select fields set
    sel(3'd2);
    drive(0, 1, 3'd0, 0, 1, 0, 0, 0, 1);
    check("R10 idle no commit", commit, 1'b0);
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R10 mode unchanged", commit, 1'b0);
    sel(3'd0);

    // R9: stop
    check("R9 halt low before", halt, 1'b0);
    sel(3'd1);
    check("R9 halt not yet", halt, 1'b0);
    drive(1, 0, 0, 0, 1, 0, 0, 0, 0);
    check("R9 halt set", halt, 1'b1);
    check("R9 suppressed", commit, 1'b0);
    sel(3'd0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R9 halt sticky", halt, 1'b1);
    do_reset();
    check("R1 halt cleared by reset", halt, 1'b0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule